// File: doc/BRIEF.md
# Serial Converter Result Reader

This block is the host-side master for a three-wire serial converter that reports its results as 24-bit status-prefixed words. A one-cycle request on `start_i` drives the chip-select low. The block then polls the data line for the end-of-conversion flag. Once the flag reads low it generates the serial clock, captures 24 bits on the rising edges, decodes the word and raises chip-select again. Raising chip-select tells the converter to begin its next conversion.

Each word carries, in order of arrival:
- an end-of-conversion bit, which must be 0;
- a filler bit, which must be 0;
- a sign bit;
- 21 result bits, MSB first.

The decoded result, sign, range flags and a protocol-error flag are presented together with a one-cycle valid pulse. They are held until the next frame completes. The serial clock half-period is a parameter counted in system clocks.

Top module: `conv_reader`

## Requirements
- R1: While `rst_ni` is low and after reset, `cs_no` is 1, `sck_o` is 0 and `valid_o` is 0.
- R2: In idle, a `start_i` high at a clock edge drives `cs_no` low at that edge. A `start_i` raised while a frame is in progress has no effect: no second frame follows.
- R3: With `cs_no` low, `sdo_i` is sampled once every `HALF_PERIOD` clocks. No rising edge of `sck_o` is issued until a sample reads 0.
- R4: Each frame has exactly 24 rising edges of `sck_o`. Each high and low phase lasts `HALF_PERIOD` clocks. `sdo_i` is captured at each rising edge, and the first captured bit is frame bit 23.
- R5: `result_o` equals frame bits 20..0. `sign_o` equals frame bit 21.
- R6: `over_o` is 1 exactly when frame bits 21 and 20 are both 1.
- R7: `under_o` is 1 exactly when frame bits 21 and 20 are both 0. Otherwise both range flags are 0.
- R8: `perr_o` is 1 exactly when frame bit 23 or frame bit 22 is 1.
- R9: The edge that ends the 24th high phase lowers `sck_o`, raises `cs_no` and pulses `valid_o` for one cycle. All decoded outputs then stay unchanged until the next frame completes.
- R10: `sck_o` is never high while `cs_no` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one frame read |
| sdo_i | input | 1 | Serial data / conversion status from the converter |
| cs_no | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock to the converter |
| valid_o | output | 1 | One-cycle pulse when a new result is presented |
| result_o | output | RES_BITS | Result bits of the frame |
| sign_o | output | 1 | Sign bit of the frame (1 = positive) |
| over_o | output | 1 | Overrange flag |
| under_o | output | 1 | Underrange flag |
| perr_o | output | 1 | Protocol error (status or filler bit not 0) |

## Verification
Frame completion and a new request can fall in the same clock edge. The bench provokes this by holding `start_i` high across the end of a frame. It then judges that `valid_o` pulses once, that `cs_no` stays high for exactly one cycle before the next frame, and that the second frame decodes correctly. A second coincidence is the end-of-conversion flag falling right at a poll sample. The converter model in the bench sweeps the busy time over random lengths so that the flag drops at every phase of the poll interval, and it reports any clock rising edge seen while the flag is still high.

// File: rtl/conv_reader_pkg.sv
package conv_reader_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POLL  = 2'd1,
    ST_SHIFT = 2'd2
  } rd_state_e;
endpackage

// File: rtl/conv_reader_tick.sv
module conv_reader_tick #(
  parameter int HALF_PERIOD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/conv_reader_shift.sv
module conv_reader_shift #(
  parameter int BITS = 24
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clear_i,
  input  logic                        shift_i,
  input  logic                        bit_i,
  output logic [BITS-1:0]             word_o,
  output logic [$clog2(BITS+1)-1:0]   count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      count_o <= '0;
    end else if (clear_i) begin
      count_o <= '0;
    end else if (shift_i) begin
      word_o  <= {word_o[BITS-2:0], bit_i};
      count_o <= count_o + 1'b1;
    end
  end
endmodule

// File: rtl/conv_reader_decode.sv
module conv_reader_decode #(
  parameter int RES_BITS = 21
) (
  input  logic [RES_BITS+2:0] word_i,
  output logic [RES_BITS-1:0] result_o,
  output logic                sign_o,
  output logic                over_o,
  output logic                under_o,
  output logic                perr_o
);
  localparam int TOP = RES_BITS + 2;

  logic msb;
  assign msb      = word_i[RES_BITS-1];
  assign result_o = word_i[RES_BITS-1:0];
  assign sign_o   = word_i[RES_BITS];
  assign over_o   = sign_o & msb;
  assign under_o  = ~sign_o & ~msb;
  // status bit must read ready, filler bit must be low
  assign perr_o   = word_i[TOP] | word_i[TOP-1];
endmodule

// File: rtl/conv_reader.sv
module conv_reader #(
  parameter int HALF_PERIOD = 4,
  parameter int RES_BITS    = 21
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                sdo_i,
  output logic                cs_no,
  output logic                sck_o,
  output logic                valid_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                sign_o,
  output logic                over_o,
  output logic                under_o,
  output logic                perr_o
);
  import conv_reader_pkg::*;

  localparam int FRAME_BITS = RES_BITS + 3;
  localparam int CNTW       = $clog2(FRAME_BITS + 1);
  localparam logic [CNTW-1:0] LAST_BIT = CNTW'(FRAME_BITS);

  rd_state_e state_q;
  logic      tick, shift_en, clear_en;
  logic [FRAME_BITS-1:0] word;
  logic [CNTW-1:0]       count;

  logic [RES_BITS-1:0] d_result;
  logic d_sign, d_over, d_under, d_perr;

  conv_reader_tick #(.HALF_PERIOD(HALF_PERIOD)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q != ST_IDLE),
    .tick_o (tick)
  );

  assign shift_en = (state_q == ST_SHIFT) && tick && !sck_o;
  assign clear_en = (state_q == ST_IDLE);

  conv_reader_shift #(.BITS(FRAME_BITS)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_en),
    .shift_i (shift_en),
    .bit_i   (sdo_i),
    .word_o  (word),
    .count_o (count)
  );

  conv_reader_decode #(.RES_BITS(RES_BITS)) u_dec (
    .word_i   (word),
    .result_o (d_result),
    .sign_o   (d_sign),
    .over_o   (d_over),
    .under_o  (d_under),
    .perr_o   (d_perr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cs_no    <= 1'b1;
      sck_o    <= 1'b0;
      valid_o  <= 1'b0;
      result_o <= '0;
      sign_o   <= 1'b0;
      over_o   <= 1'b0;
      under_o  <= 1'b0;
      perr_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cs_no   <= 1'b0;
          state_q <= ST_POLL;
        end
        ST_POLL: if (tick && !sdo_i) state_q <= ST_SHIFT;
        ST_SHIFT: if (tick) begin
          if (!sck_o) begin
            sck_o <= 1'b1;
          end else begin
            sck_o <= 1'b0;
            if (count == LAST_BIT) begin
              cs_no    <= 1'b1;
              valid_o  <= 1'b1;
              result_o <= d_result;
              sign_o   <= d_sign;
              over_o   <= d_over;
              under_o  <= d_under;
              perr_o   <= d_perr;
              state_q  <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/conv_reader_chk.sv
module conv_reader_chk #(
  parameter int RES_BITS = 21
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                cs_no,
  input logic                sck_o,
  input logic                valid_o,
  input logic [RES_BITS-1:0] result_o,
  input logic                sign_o,
  input logic                over_o,
  input logic                under_o,
  input logic                perr_o
);
  // R10
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);

  // R9
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R9
  valid_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cs_no);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable({result_o, sign_o, over_o, under_o, perr_o}));

  // R7
  range_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(over_o && under_o));

  // R2
  cs_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(start_i));
endmodule

bind conv_reader conv_reader_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .cs_no    (cs_no),
  .sck_o    (sck_o),
  .valid_o  (valid_o),
  .result_o (result_o),
  .sign_o   (sign_o),
  .over_o   (over_o),
  .under_o  (under_o),
  .perr_o   (perr_o)
);

// File: tb/conv_reader_test.sv
module conv_reader_test;
  localparam int HALF = 4;
  localparam int RB   = 21;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sdo;
  logic cs_n, sck, valid, sign, over, under, perr;
  logic [RB-1:0] result;

  int tests = 0, fails = 0;
  int rises, early, busy_set, busy_left, low_cyc, idx;
  bit bad_eoc;
  logic [23:0] mword;
  logic cs_d, sck_d;

  always #4 clk = ~clk;

  conv_reader #(.HALF_PERIOD(HALF), .RES_BITS(RB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sdo_i(sdo),
    .cs_no(cs_n), .sck_o(sck), .valid_o(valid), .result_o(result),
    .sign_o(sign), .over_o(over), .under_o(under), .perr_o(perr)
  );

  // converter model: status while busy, data updated on falling clock
  always @(posedge clk) begin
    cs_d  <= cs_n;
    sck_d <= sck;
    if (cs_d && !cs_n) begin
      idx       <= 23;
      busy_left <= busy_set;
      low_cyc   <= 0;
      sdo       <= (busy_set != 0);
    end else if (!cs_n) begin
      low_cyc <= low_cyc + 1;
      if (busy_left > 0) begin
        busy_left <= busy_left - 1;
        sdo       <= (busy_left > 1);
      end
      if (bad_eoc && low_cyc == HALF + 1) sdo <= 1'b1;
      if (sck_d && !sck && idx > 0) begin
        idx <= idx - 1;
        sdo <= mword[idx-1];
      end
      if (!sck_d && sck) begin
        rises <= rises + 1;
        if (busy_left > 0) early <= early + 1;
      end
    end else begin
      sdo <= 1'b1;
    end
  end

  function automatic logic f_over(input logic [23:0] w);
    return w[21] & w[20];
  endfunction
  function automatic logic f_under(input logic [23:0] w);
    return ~w[21] & ~w[20];
  endfunction
  function automatic logic f_perr(input logic [23:0] w);
    return w[23] | w[22];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_valid(output bit seen);
    int n = 0;
    seen = 0;
    while (n < 5000) begin
      @(negedge clk);
      if (valid) begin seen = 1; break; end
      n++;
    end
    if (!seen) check(0, "R9 timeout", 0, 1);
  endtask

  task automatic check_word(input logic [23:0] w);
    check(result == w[20:0], "R5 result", result, w[20:0]);
    check(sign == w[21], "R5 sign", sign, w[21]);
    check(over == f_over(w), "R6 over", over, f_over(w));
    check(under == f_under(w), "R7 under", under, f_under(w));
    check(perr == f_perr(w), "R8 perr", perr, f_perr(w));
  endtask

  task automatic do_frame(input logic [22:0] low23, input int busy, input bit bad, input bit mid_start);
    bit seen;
    logic [23:0] w;
    mword = {1'b0, low23};
    busy_set = busy;
    bad_eoc = bad;
    rises = 0;
    early = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) begin
      start = 1'b0;
      check(cs_n == 1'b0, "R2 cs low", cs_n, 0);
    end
    if (mid_start) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    wait_valid(seen);
    if (seen) begin
      w = {bad, low23};
      check(cs_n == 1'b1 && sck == 1'b0, "R9 close", {cs_n, sck}, 2'b10);
      check(rises == 24, "R4 edges", rises, 24);
      check(early == 0, "R3 early sck", early, 0);
      check_word(w);
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (valid || !cs_n) begin
          check(0, "R2 R9 idle hold", {valid, cs_n}, 2'b01);
          break;
        end
      end
      check(result == w[20:0] && sign == w[21], "R9 held", result, w[20:0]);
    end
    bad_eoc = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit seen;
    int hi;
    void'($urandom(32'd2718));
    busy_set = 0; bad_eoc = 0; mword = '0;
    repeat (3) @(negedge clk);
    check(cs_n && !sck && !valid, "R1 in reset", {cs_n, sck, valid}, 3'b100);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cs_n && !sck && !valid, "R1 after reset", {cs_n, sck, valid}, 3'b100);

    // R6 R7 directed range codes, R3 long busy
    do_frame({1'b0, 1'b1, 1'b1, 20'h00012}, 0, 0, 0);
    do_frame({1'b0, 1'b0, 1'b0, 20'hFFFFF}, 37, 0, 0);
    do_frame({1'b0, 1'b1, 1'b0, 20'hABCDE}, 5, 0, 0);
    do_frame({1'b0, 1'b0, 1'b1, 20'h00001}, 120, 0, 0);
    // R8 filler set, status set
    do_frame({1'b1, 1'b1, 1'b0, 20'h55555}, 3, 0, 0);
    do_frame({1'b0, 1'b1, 1'b0, 20'h12345}, 0, 1, 0);
    // R2 start mid frame ignored
    do_frame({1'b0, 1'b0, 1'b1, 20'h0F0F0}, 9, 0, 1);

    // R2 R9 start held across frame end
    mword = {2'b00, 1'b1, 1'b0, 20'h2468A};
    busy_set = 2; rises = 0; early = 0;
    @(negedge clk) start = 1'b1;
    wait_valid(seen);
    if (seen) begin
      check_word(mword);
      @(negedge clk);
      check(cs_n == 1'b0, "R2 back to back", cs_n, 0);
      start = 1'b0;
      mword = {2'b00, 1'b0, 1'b1, 20'h13579};
      rises = 0;
      hi = 0;
      wait_valid(seen);
      if (seen) begin
        check_word(mword);
        check(rises == 24, "R4 edges b2b", rises, 24);
      end
    end
    start = 1'b0;

    // random frames
    for (int k = 0; k < 40; k++) begin
      logic [22:0] r;
      r = 23'($urandom);
      r[22] = 1'b0;
      do_frame(r, int'($urandom % 24), 0, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule